// File: doc/BRIEF.md
# Fractional-Rate Master Counter

This block keeps a free-running 64-bit tick count that advances at a fixed nominal rate of 6.144 MHz, whatever the frequency of the clock that drives it. The rate is set by a programmable fraction. On each clock cycle a numerator is added into an accumulator. When the accumulator reaches a denominator, the denominator is taken back out and the count steps by one. Each supported reference clock therefore needs only its own numerator/denominator pair. For example, 38.4 MHz uses 4/25, 19.2 MHz uses 8/25, 12 MHz uses 64/125, 27 MHz uses 256/1125, 26 MHz uses 384/1625 and 13 MHz uses 768/1625. The 38.4 MHz pair is the reset default.

Software reaches the block through a simple word-wide register port. It can read the two fraction registers, change their low 12-bit fields while keeping the other bits, and read the count as a low and a high 32-bit word. Reading the low word captures the high word at the same instant, so a later read of the high word pairs with it.

Top module: `frac_master_counter`

## Requirements
- R1: After reset the count and the accumulator are zero, the numerator word reads 4 and the denominator word reads 25.
- R2: With a valid ratio, every clock adds the numerator (bits 11:0 of its word) to the accumulator. When the sum is at least the denominator (bits 11:0 of its word), the denominator is subtracted and the count rises by one. So N clock edges after the accumulator is cleared, the count has risen by floor(N*num/den).
- R3: The count rises by at most one per clock, and a numerator equal to the denominator gives exactly one step on every clock.
- R4: A denominator of zero, or a numerator greater than the denominator, is an invalid ratio, and the count then holds its value.
- R5: A write to the denominator word clears the accumulator, and no count step happens on the edge of that write.
- R6: The register offsets are: count low word 0x00, count high word 0x04, numerator 0x10, denominator 0x14. A read of any other offset returns zero, and a write to any other offset changes nothing.
- R7: Both fraction words store all 32 written bits and read them back unchanged. Only bits 11:0 affect the rate.
- R8: A read of the count low word captures the current upper 32 bits of the count. A read of offset 0x04 returns that captured value.
- R9: Read data is registered. It shows the addressed word on the clock after the edge that sampled the read strobe, and it holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the count steps on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_rd_en | input | 1 | Read strobe for one cycle |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default parameters: a 64-bit count and 12-bit fraction fields. These defaults hold every listed reference-clock pair, the invalid-ratio cases and the full register layout. Random fraction values up to 4095 reach the accumulator's widest sums. A count wide enough to carry into the high word within a run is beyond reach, so the high-word capture is only checked with a zero upper half; the bound checker covers the capture at every low-word read.

// File: rtl/frac_cnt_pkg.sv
package frac_cnt_pkg;

   localparam int          REG_AW     = 8;
   localparam logic [7:0]  OFS_CNT_LO = 8'h00;
   localparam logic [7:0]  OFS_CNT_HI = 8'h04;
   localparam logic [7:0]  OFS_NUM    = 8'h10;
   localparam logic [7:0]  OFS_DEN    = 8'h14;

   // default ratio: 38.4 MHz reference -> 6.144 MHz
   localparam logic [31:0] RST_NUM_WORD = 32'd4;
   localparam logic [31:0] RST_DEN_WORD = 32'd25;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_LO,
      SEL_HI,
      SEL_NUM,
      SEL_DEN
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [REG_AW-1:0] ofs);
      reg_sel_e s;
      case (ofs)
         OFS_CNT_LO: s = SEL_LO;
         OFS_CNT_HI: s = SEL_HI;
         OFS_NUM:    s = SEL_NUM;
         OFS_DEN:    s = SEL_DEN;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/frac_cnt_regs.sv
module frac_cnt_regs
   import frac_cnt_pkg::*;
#(
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [31:0]       wdata,
   output logic [31:0]       num_word,
   output logic [31:0]       den_word,
   output logic [FRAC_W-1:0] num_f,
   output logic [FRAC_W-1:0] den_f,
   output logic              den_wr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_word <= RST_NUM_WORD;
         den_word <= RST_DEN_WORD;
      end else if (wr_en) begin
         if (sel == SEL_NUM) num_word <= wdata;
         if (sel == SEL_DEN) den_word <= wdata;
      end
   end

   assign num_f  = num_word[FRAC_W-1:0];
   assign den_f  = den_word[FRAC_W-1:0];
   assign den_wr = wr_en && (sel == SEL_DEN);

endmodule

// File: rtl/frac_cnt_step.sv
module frac_cnt_step #(
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [FRAC_W-1:0] num,
   input  logic [FRAC_W-1:0] den,
   output logic              inc,
   output logic [FRAC_W-1:0] acc_o
);

   localparam int SUM_W = FRAC_W + 1;

   logic [FRAC_W-1:0] acc_q;
   logic [SUM_W-1:0]  sum;
   logic [SUM_W-1:0]  rem;
   logic              ratio_ok;
   logic              wrap;

   assign ratio_ok = (den != '0) && (num <= den);
   assign sum      = {1'b0, acc_q} + {1'b0, num};
   assign wrap     = sum >= {1'b0, den};
   assign rem      = sum - {1'b0, den};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (ratio_ok) begin
         acc_q <= wrap ? rem[FRAC_W-1:0] : sum[FRAC_W-1:0];
      end
   end

   assign inc   = ratio_ok && !clr && wrap;
   assign acc_o = acc_q;

endmodule

// File: rtl/frac_cnt_core.sv
module frac_cnt_core
   import frac_cnt_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             rd_en,
   input  reg_sel_e         sel,
   input  logic [31:0]      num_word,
   input  logic [31:0]      den_word,
   output logic [31:0]      rdata,
   output logic [CNT_W-1:0] cnt_o,
   output logic [31:0]      hi_hold_o
);

   localparam int HI_W = CNT_W - 32;

   logic [CNT_W-1:0] cnt_q;
   logic [31:0]      hi_now;
   logic [31:0]      hi_hold;

   generate
      if (HI_W == 32) begin : g_hi_full
         assign hi_now = cnt_q[CNT_W-1:32];
      end else begin : g_hi_ext
         assign hi_now = {{(32-HI_W){1'b0}}, cnt_q[CNT_W-1:32]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_hold <= '0;
         rdata   <= '0;
      end else if (rd_en) begin
         case (sel)
            SEL_LO: begin
               rdata   <= cnt_q[31:0];
               hi_hold <= hi_now;
            end
            SEL_HI:  rdata <= hi_hold;
            SEL_NUM: rdata <= num_word;
            SEL_DEN: rdata <= den_word;
            default: rdata <= '0;
         endcase
      end
   end

   assign cnt_o     = cnt_q;
   assign hi_hold_o = hi_hold;

endmodule

// File: rtl/frac_master_counter.sv
module frac_master_counter
   import frac_cnt_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);

   generate
      if (CNT_W < 33 || CNT_W > 64) begin : g_bad_cnt_w
         $error("CNT_W must lie in 33..64");
      end
      if (FRAC_W < 5 || FRAC_W > 31) begin : g_bad_frac_w
         $error("FRAC_W must lie in 5..31");
      end
   endgenerate

   reg_sel_e          sel;
   logic [31:0]       num_word;
   logic [31:0]       den_word;
   logic [FRAC_W-1:0] num_f;
   logic [FRAC_W-1:0] den_f;
   logic              den_wr;
   logic              inc;
   logic [FRAC_W-1:0] acc_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [31:0]       hi_hold;

   assign sel = decode_ofs(reg_addr);

   frac_cnt_regs #(.FRAC_W(FRAC_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .sel      (sel),
      .wdata    (reg_wdata),
      .num_word (num_word),
      .den_word (den_word),
      .num_f    (num_f),
      .den_f    (den_f),
      .den_wr   (den_wr)
   );

   frac_cnt_step #(.FRAC_W(FRAC_W)) i_step (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (den_wr),
      .num   (num_f),
      .den   (den_f),
      .inc   (inc),
      .acc_o (acc_q)
   );

   frac_cnt_core #(.CNT_W(CNT_W)) i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (inc),
      .rd_en     (reg_rd_en),
      .sel       (sel),
      .num_word  (num_word),
      .den_word  (den_word),
      .rdata     (reg_rdata),
      .cnt_o     (cnt_q),
      .hi_hold_o (hi_hold)
   );

endmodule

// File: rtl/frac_cnt_chk.sv
module frac_cnt_chk
   import frac_cnt_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int FRAC_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input reg_sel_e          sel,
   input logic              den_wr,
   input logic [FRAC_W-1:0] num,
   input logic [FRAC_W-1:0] den,
   input logic [FRAC_W-1:0] acc,
   input logic [CNT_W-1:0]  cnt,
   input logic [31:0]       hi_hold,
   input logic [31:0]       rdata
);

   logic ratio_ok;
   assign ratio_ok = (den != '0) && (num <= den);

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt - $past(cnt)) <= CNT_W'(1)); // R3

   AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
      (den != '0) |-> (acc < den)); // R2

   AST_HOLD_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!ratio_ok && !den_wr) |=> $stable(cnt)); // R4

   AST_DEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      den_wr |=> (acc == '0) && $stable(cnt)); // R5

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_NONE) |=> (rdata == 32'd0)); // R6

   AST_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_LO) |=> (hi_hold == 32'($past(cnt[CNT_W-1:32])))); // R8

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata)); // R9

endmodule

bind frac_master_counter frac_cnt_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_en   (reg_rd_en),
   .sel     (sel),
   .den_wr  (den_wr),
   .num     (num_f),
   .den     (den_f),
   .acc     (acc_q),
   .cnt     (cnt_q),
   .hi_hold (hi_hold),
   .rdata   (reg_rdata)
);

// File: tb/test_frac_master_counter.sv
`timescale 1ns/1ps
module test_frac_master_counter;
   import frac_cnt_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   frac_master_counter i_frac_master_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr_en (wr_en),
      .reg_rd_en (rd_en),
      .reg_addr  (addr),
      .reg_wdata (wdata),
      .reg_rdata (rdata)
   );

   // reference model built from the requirements
   logic [63:0] m_cnt;
   logic [31:0] m_num_w, m_den_w, m_hi;
   logic [12:0] m_acc;
   logic [11:0] m_n, m_d;
   assign m_n = m_num_w[11:0];
   assign m_d = m_den_w[11:0];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0; m_acc <= '0; m_hi <= '0;
         m_num_w <= 32'd4; m_den_w <= 32'd25;
      end else begin
         if (wr_en && addr == OFS_DEN) begin
            m_den_w <= wdata;
            m_acc   <= '0;
         end else if (m_d != 0 && m_n <= m_d) begin
            if (m_acc + 13'(m_n) >= 13'(m_d)) begin
               m_acc <= m_acc + 13'(m_n) - 13'(m_d);
               m_cnt <= m_cnt + 64'd1;
            end else begin
               m_acc <= m_acc + 13'(m_n);
            end
         end
         if (wr_en && addr == OFS_NUM) m_num_w <= wdata;
         if (rd_en && addr == OFS_CNT_LO) m_hi <= m_cnt[63:32];
      end
   end

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         OFS_CNT_LO: return m_cnt[31:0];
         OFS_CNT_HI: return m_hi;
         OFS_NUM:    return m_num_w;
         OFS_DEN:    return m_den_w;
         default:    return 32'd0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] e);
      rd_en = 1'b1; addr = a;
      e = exp_read(a);
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic rd_chk(input logic [7:0] a, input string req);
      logic [31:0] v, e;
      rd(a, v, e);
      chk(req, 64'(v), 64'(e));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // writes num then den, then measures the count rise over m+1 edges
   task automatic ratio_run(input logic [31:0] nw, input logic [31:0] dw,
                            input int m, input string req);
      logic [31:0] c0, c1, e;
      logic [63:0] n, d, want;
      wr(OFS_NUM, nw);
      wr(OFS_DEN, dw);
      rd(OFS_CNT_LO, c0, e);
      chk(req, 64'(c0), 64'(e));
      idle(m);
      rd(OFS_CNT_LO, c1, e);
      chk(req, 64'(c1), 64'(e));
      n = 64'(nw[11:0]);
      d = 64'(dw[11:0]);
      want = (d == 0 || n > d) ? 64'd0 : ((64'(m) + 64'd1) * n) / d;
      chk(req, 64'(c1 - c0), want);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v, e, va, vb;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(OFS_CNT_LO, v, e);   chk("R1", 64'(v), 64'd0);
      rd(OFS_NUM, v, e);      chk("R1", 64'(v), 64'd4);
      rd(OFS_DEN, v, e);      chk("R1", 64'(v), 64'd25);
      rd(OFS_CNT_HI, v, e);   chk("R8", 64'(v), 64'd0);

      // R2 every reference-clock ratio
      ratio_run(32'd4,   32'd25,   300, "R2");
      ratio_run(32'd8,   32'd25,   300, "R2");
      ratio_run(32'd64,  32'd125,  400, "R2");
      ratio_run(32'd768, 32'd1625, 1000, "R2");
      ratio_run(32'd384, 32'd1625, 1000, "R2");
      ratio_run(32'd256, 32'd1125, 700, "R2");

      // R3 num equal to den: one step every clock
      ratio_run(32'd25, 32'd25, 50, "R3");
      ratio_run(32'd4095, 32'd4095, 9, "R3");

      // R4 invalid ratios hold the count
      ratio_run(32'd30, 32'd25, 40, "R4");
      ratio_run(32'd3, 32'd0, 40, "R4");

      // R5 den write clears accumulator and skips its own step
      ratio_run(32'd24, 32'd25, 13, "R5");
      ratio_run(32'd24, 32'd25, 3, "R5");
      wr(OFS_NUM, 32'd25);
      wr(OFS_DEN, 32'd25);
      rd(OFS_CNT_LO, va, e);
      wr(OFS_DEN, 32'd25);
      rd(OFS_CNT_LO, vb, e);
      chk("R5", 64'(vb - va), 64'd1);

      // R6 unmapped offsets
      rd(8'h08, v, e);  chk("R6", 64'(v), 64'd0);
      wr(8'h20, 32'hFFFF_FFFF);
      rd(OFS_NUM, v, e); chk("R6", 64'(v), 64'd25);
      rd(OFS_DEN, v, e); chk("R6", 64'(v), 64'd25);

      // R7 upper bits kept, only low 12 bits set the rate
      ratio_run(32'hABCD_E008, 32'h1234_5019, 250, "R7");
      rd(OFS_NUM, v, e); chk("R7", 64'(v), 64'hABCD_E008);
      rd(OFS_DEN, v, e); chk("R7", 64'(v), 64'h1234_5019);

      // R8 high word captured by low read
      rd_chk(OFS_CNT_LO, "R8");
      rd(OFS_CNT_HI, v, e); chk("R8", 64'(v), 64'(e));

      // R9 read data holds while no read is strobed
      rd(OFS_CNT_LO, va, e);
      idle(20);
      chk("R9", 64'(rdata), 64'(va));

      // constrained random mix checked against the model
      for (int i = 0; i < 400; i++) begin
         int op;
         op = int'($urandom_range(0, 5));
         case (op)
            0: begin
               int k;
               k = int'($urandom_range(0, 5));
               case (k)
                  0: begin wr(OFS_NUM, 32'd4);   wr(OFS_DEN, 32'd25);   end
                  1: begin wr(OFS_NUM, 32'd8);   wr(OFS_DEN, 32'd25);   end
                  2: begin wr(OFS_NUM, 32'd64);  wr(OFS_DEN, 32'd125);  end
                  3: begin wr(OFS_NUM, 32'd768); wr(OFS_DEN, 32'd1625); end
                  4: begin wr(OFS_NUM, 32'd384); wr(OFS_DEN, 32'd1625); end
                  default: begin wr(OFS_NUM, 32'd256); wr(OFS_DEN, 32'd1125); end
               endcase
            end
            1: wr(OFS_NUM, $urandom());
            2: wr(OFS_DEN, $urandom());
            3: begin
               logic [7:0] a;
               int s;
               s = int'($urandom_range(0, 4));
               a = (s == 0) ? OFS_CNT_LO : (s == 1) ? OFS_CNT_HI :
                   (s == 2) ? OFS_NUM : (s == 3) ? OFS_DEN : 8'h0C;
               rd_chk(a, "R2");
            end
            4: rd_chk(OFS_CNT_LO, "R2");
            default: idle(int'($urandom_range(0, 20)));
         endcase
      end
      rd_chk(OFS_CNT_LO, "R2");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule